// File: doc/BRIEF.md
# Fuse Array Command Sequencer

This block sits between a simple register bus and a one-time-programmable fuse array. It has read and write strobes, a 12-bit byte address and 32-bit data. Software first raises a power request and waits for the fuse macro to report that power is up. It then issues shadow-read, program and lock commands through a control register and polls a status register until the command has finished.

A shadow-read copies a fuse word into a window of shadow registers that software can read and overwrite freely. A program command ORs a staged data word into a fuse word. A lock command makes a word refuse any later programming. Per-word error and disturbed flags are kept in bitmaps of 32 words per register.

The fuse macro is modelled inside the block. It is a register array with a parameterised busy latency, a parameterised power-up latency, an initial image, and a map of weak words that report a disturbed read.

Top module: `fuse_cmd_seq`

## Requirements
- R1: After reset, the following all read as zero: the configuration register, status bits 3, 4 and 5, the shadow window and both flag bitmaps.
- R2: Bit 0 of the configuration register (0x000) is the power request. Status (0x00C) bit 5 rises PWR_LAT cycles after the request is set, and falls PWR_LAT cycles after it is cleared.
- R3: A control write (0x004) made while status bit 5 is low is ignored. Status bit 3 stays low and no fuse or shadow state changes.
- R4: An accepted command drives status bit 3 high from the clock edge that captures the control write until its result is visible. A control write made while bit 3 is high is ignored.
- R5: The control word is laid out as index in bits [IDX_W-1:0] and operation in bits [9:8]. Operation 0 (0x000) is a shadow-read: it copies fuse word N into the shadow slot at byte address 0x200 + 4·N.
- R6: Operation 1 (0x100) is a program: it ORs the value held in the write-data register (0x008) into fuse word N.
- R7: Operation 3 (0x300) is a program with lock: it locks word N. A later program of a locked word leaves the word unchanged and sets status bit 4. The next accepted command clears bit 4.
- R8: A control write whose index exceeds NUM_WORDS-1 starts no command. It sets error bit index[4:0] in the error bank register at 0x034 + (index>>5)·4.
- R9: On completion, a shadow-read loads the disturbed bit of word N with that word's weak flag. The disturbed bank register sits at 0x01C + (N>>5)·4, bit N[4:0].
- R10: A bus write to a shadow slot changes only the shadow copy. A later shadow-read of that word returns the unchanged fuse value.
- R11: Status bit 0 mirrors the secured-mode input, and status bit 2 mirrors the invalid-state input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lc_secured_i | input | 1 | Secured-mode indication, shown in status |
| lc_invalid_i | input | 1 | Invalid security state indication, shown in status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the read strobe |

## Verification
The hardest cases to reach from the ports are a command that lands while an earlier one is still running, and a program aimed at a locked word. The first is reached by writing a second control word straight after an accepted one, within the busy window. The result is then judged by a later shadow-read of the untouched word. The locked-word case is reached by first locking a word and then programming all ones into it. The bench then watches status bit 4 and confirms through a shadow-read that the stored word did not change.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] A_CFG  = 12'h000;
  localparam logic [ADDR_W-1:0] A_CTRL = 12'h004;
  localparam logic [ADDR_W-1:0] A_WDAT = 12'h008;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h00C;
  localparam logic [ADDR_W-1:0] A_DIST = 12'h01C;
  localparam logic [ADDR_W-1:0] A_ERR  = 12'h034;
  localparam logic [ADDR_W-1:0] A_SHAD = 12'h200;

  localparam int ST_SEC  = 0;
  localparam int ST_INV  = 2;
  localparam int ST_BUSY = 3;
  localparam int ST_FAIL = 4;
  localparam int ST_PWR  = 5;

  localparam int OP_LSB = 8;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_PROG = 2'd1,
    OP_LRD  = 2'd2,
    OP_LPRG = 2'd3
  } fuse_op_e;
endpackage

// File: rtl/fuse_pwr_ctl.sv
module fuse_pwr_ctl #(
  parameter int PWR_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic pwr_ok_o
);
  localparam int CW = $clog2(PWR_LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ok_q, ok_d;

  always_comb begin
    cnt_d = cnt_q;
    ok_d  = ok_q;
    if (req_i == ok_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(PWR_LAT - 1)) begin
      cnt_d = '0;
      ok_d  = req_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign pwr_ok_o = ok_q;
endmodule

// File: rtl/fuse_array_model.sv
module fuse_array_model
  import fuse_seq_pkg::*;
#(
  parameter int                     NUM_WORDS = 96,
  parameter int                     IDX_W     = 7,
  parameter int                     BUSY_LAT  = 4,
  parameter logic [NUM_WORDS*32-1:0] INIT_IMG = '0,
  parameter logic [NUM_WORDS-1:0]    WEAK_MAP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  fuse_op_e         op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output fuse_op_e         done_op_o,
  output logic [IDX_W-1:0] done_idx_o,
  output logic [31:0]      rd_data_o,
  output logic             dist_o,
  output logic             fail_o
);
  localparam int CW = $clog2(BUSY_LAT + 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q;
  fuse_op_e         op_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      wdat_q;
  logic [31:0]      rdat_q;
  logic             dist_q;
  logic             fail_q, fail_d;
  logic             fin;
  logic [31:0]      fuse_q [NUM_WORDS];
  logic             lock_q [NUM_WORDS];

  assign fin = busy_q && (cnt_q == CW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fail_d = fail_q;
    if (start_i) begin
      cnt_d  = CW'(BUSY_LAT);
      busy_d = 1'b1;
      fail_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
      if (fin) begin
        busy_d = 1'b0;
        if (op_q == OP_PROG && lock_q[idx_q]) fail_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      fail_q <= fail_d;
      done_q <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_READ;
      idx_q  <= '0;
      wdat_q <= '0;
    end else if (start_i) begin
      op_q   <= op_i;
      idx_q  <= idx_i;
      wdat_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
      dist_q <= 1'b0;
    end else if (fin) begin
      rdat_q <= fuse_q[idx_q];
      dist_q <= WEAK_MAP[idx_q];
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit, prog_en, lock_en;
    assign hit     = fin && (idx_q == IDX_W'(w));
    assign prog_en = hit && (op_q == OP_PROG) && !lock_q[w];
    assign lock_en = hit && (op_q == OP_LPRG);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fuse_q[w] <= INIT_IMG[w*32 +: 32];
      end else if (prog_en) begin
        fuse_q[w] <= fuse_q[w] | wdat_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q[w] <= 1'b0;
      end else if (lock_en) begin
        lock_q[w] <= 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign done_op_o  = op_q;
  assign done_idx_o = idx_q;
  assign rd_data_o  = rdat_q;
  assign dist_o     = dist_q;
  assign fail_o     = fail_q;
endmodule

// File: rtl/fuse_flag_banks.sv
module fuse_flag_banks #(
  parameter int IDX_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  err_set_i,
  input  logic [IDX_W-1:0]      err_idx_i,
  input  logic                  upd_i,
  input  logic [IDX_W-1:0]      upd_idx_i,
  input  logic                  upd_dist_i,
  output logic [(1<<IDX_W)-1:0] err_map_o,
  output logic [(1<<IDX_W)-1:0] dist_map_o
);
  localparam int NBITS = 1 << IDX_W;

  logic [NBITS-1:0] err_q, err_d, dist_q, dist_d;

  always_comb begin
    err_d  = err_q;
    dist_d = dist_q;
    if (upd_i) begin
      err_d[upd_idx_i]  = 1'b0;
      dist_d[upd_idx_i] = upd_dist_i;
    end
    if (err_set_i) err_d[err_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      dist_q <= '0;
    end else begin
      err_q  <= err_d;
      dist_q <= dist_d;
    end
  end

  assign err_map_o  = err_q;
  assign dist_map_o = dist_q;
endmodule

// File: rtl/fuse_cmd_seq.sv
module fuse_cmd_seq
  import fuse_seq_pkg::*;
#(
  parameter int                     NUM_WORDS = 96,
  parameter int                     IDX_W     = 7,
  parameter int                     BUSY_LAT  = 4,
  parameter int                     PWR_LAT   = 3,
  parameter logic [NUM_WORDS*32-1:0] INIT_IMG = '0,
  parameter logic [NUM_WORDS-1:0]    WEAK_MAP = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lc_secured_i,
  input  logic        lc_invalid_i,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  // index must fit below the operation field at bit 8
  localparam int NBITS = 1 << IDX_W;
  localparam int NBANK = NBITS / 32;
  localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic rst_meta_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  logic             cfg_pwr_q;
  logic [31:0]      wdat_q;
  logic [IDX_W+1:0] ctrl_q;
  logic [31:0]      rdata_q, rd_mux;

  logic             ctrl_wr, ctrl_oor, start;
  logic [IDX_W-1:0] cmd_idx;
  fuse_op_e         cmd_op;
  logic             pwr_ok, stat_busy;
  logic             mac_busy, mac_done, mac_dist, prog_fail;
  fuse_op_e         mac_op;
  logic [IDX_W-1:0] mac_idx;
  logic [31:0]      mac_rdata;
  logic [NBITS-1:0] err_map, dist_map;
  logic [31:0]      status;
  logic [31:0]      shadow_q [NUM_WORDS];

  logic [11:0]      dist_off, err_off, sh_off;
  logic             dist_hit, err_hit, sh_hit, sh_wr;
  logic [BW-1:0]    dist_bk, err_bk;
  logic [IDX_W-1:0] sh_idx;

  assign cmd_idx   = bus_wdata[IDX_W-1:0];
  assign cmd_op    = fuse_op_e'(bus_wdata[OP_LSB +: 2]);
  assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
  assign ctrl_oor  = !(32'(cmd_idx) < 32'(NUM_WORDS));
  assign stat_busy = mac_busy || mac_done;
  assign start     = ctrl_wr && !ctrl_oor && pwr_ok && !stat_busy;

  assign dist_off = bus_addr - A_DIST;
  assign err_off  = bus_addr - A_ERR;
  assign sh_off   = bus_addr - A_SHAD;
  assign dist_hit = (bus_addr >= A_DIST) && (dist_off < 12'(4 * NBANK)) && (bus_addr[1:0] == 2'b00);
  assign err_hit  = (bus_addr >= A_ERR) && (err_off < 12'(4 * NBANK)) && (bus_addr[1:0] == 2'b00);
  assign sh_hit   = (bus_addr >= A_SHAD) && (sh_off < 12'(4 * NUM_WORDS)) && (bus_addr[1:0] == 2'b00);
  assign dist_bk  = dist_off[BW+1:2];
  assign err_bk   = err_off[BW+1:2];
  assign sh_idx   = sh_off[IDX_W+1:2];
  assign sh_wr    = bus_wr && sh_hit;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cfg_pwr_q <= 1'b0;
    else if (bus_wr && bus_addr == A_CFG) cfg_pwr_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) wdat_q <= '0;
    else if (bus_wr && bus_addr == A_WDAT) wdat_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= {bus_wdata[OP_LSB +: 2], cmd_idx};
  end

  fuse_pwr_ctl #(.PWR_LAT(PWR_LAT)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_ns),
    .req_i    (cfg_pwr_q),
    .pwr_ok_o (pwr_ok)
  );

  fuse_array_model #(
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W),
    .BUSY_LAT  (BUSY_LAT),
    .INIT_IMG  (INIT_IMG),
    .WEAK_MAP  (WEAK_MAP)
  ) u_mac (
    .clk        (clk),
    .rst_n      (rst_ns),
    .start_i    (start),
    .op_i       (cmd_op),
    .idx_i      (cmd_idx),
    .wdata_i    (wdat_q),
    .busy_o     (mac_busy),
    .done_o     (mac_done),
    .done_op_o  (mac_op),
    .done_idx_o (mac_idx),
    .rd_data_o  (mac_rdata),
    .dist_o     (mac_dist),
    .fail_o     (prog_fail)
  );

  fuse_flag_banks #(.IDX_W(IDX_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_ns),
    .err_set_i  (ctrl_wr && ctrl_oor),
    .err_idx_i  (cmd_idx),
    .upd_i      (mac_done && mac_op == OP_READ),
    .upd_idx_i  (mac_idx),
    .upd_dist_i (mac_dist),
    .err_map_o  (err_map),
    .dist_map_o (dist_map)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_shadow
    logic ld_fuse, ld_bus;
    assign ld_fuse = mac_done && (mac_op == OP_READ) && (mac_idx == IDX_W'(w));
    assign ld_bus  = sh_wr && (sh_idx == IDX_W'(w));
    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) shadow_q[w] <= '0;
      else if (ld_bus) shadow_q[w] <= bus_wdata;
      else if (ld_fuse) shadow_q[w] <= mac_rdata;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_SEC]  = lc_secured_i;
    status[ST_INV]  = lc_invalid_i;
    status[ST_BUSY] = stat_busy;
    status[ST_FAIL] = prog_fail;
    status[ST_PWR]  = pwr_ok;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_CFG)       rd_mux = {31'd0, cfg_pwr_q};
    else if (bus_addr == A_CTRL) rd_mux = 32'(ctrl_q);
    else if (bus_addr == A_WDAT) rd_mux = wdat_q;
    else if (bus_addr == A_STAT) rd_mux = status;
    else if (dist_hit)           rd_mux = dist_map[32*int'(dist_bk) +: 32];
    else if (err_hit)            rd_mux = err_map[32*int'(err_bk) +: 32];
    else if (sh_hit)             rd_mux = shadow_q[sh_idx];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/fuse_cmd_seq_chk.sv
module fuse_cmd_seq_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             pwr_req,
  input logic             pwr_ok,
  input logic             ctrl_wr,
  input logic             ctrl_oor,
  input logic             stat_busy,
  input logic             mac_busy,
  input logic             mac_done,
  input logic [IDX_W-1:0] mac_idx,
  input logic             prog_fail
);
  p_pwr_rise_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(pwr_ok) |-> pwr_req);

  p_start_needs_pwr_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(mac_busy) |-> $past(pwr_ok));

  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctrl_wr && stat_busy) |=> $stable(mac_idx));

  p_fail_at_done_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(prog_fail) |-> mac_done);

  p_oor_no_start_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctrl_wr && ctrl_oor) |=> !$rose(mac_busy));
endmodule

bind fuse_cmd_seq fuse_cmd_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .pwr_req   (cfg_pwr_q),
  .pwr_ok    (pwr_ok),
  .ctrl_wr   (ctrl_wr),
  .ctrl_oor  (ctrl_oor),
  .stat_busy (stat_busy),
  .mac_busy  (mac_busy),
  .mac_done  (mac_done),
  .mac_idx   (mac_idx),
  .prog_fail (prog_fail)
);

// File: tb/fuse_cmd_seq_tb_top.sv
module fuse_cmd_seq_tb_top;
  localparam int NW = 96;
  localparam int IW = 7;
  localparam int BL = 5;
  localparam int PL = 3;
  localparam logic [NW-1:0] WEAK = (NW'(1) << 5) | (NW'(1) << 32);

  function automatic logic [31:0] img(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'h5A, 8'h03, ~b, 8'h40};
  endfunction

  function automatic logic [NW*32-1:0] build_img();
    logic [NW*32-1:0] v;
    v = '0;
    for (int i = 0; i < NW; i++) v[i*32 +: 32] = img(i);
    return v;
  endfunction

  localparam logic [NW*32-1:0] IMG = build_img();

  localparam int VEC_N = 6;
  localparam logic [6:0] VEC_IDX  [VEC_N] = '{7'd0, 7'd5, 7'd17, 7'd31, 7'd32, 7'd95};
  localparam logic       VEC_DIST [VEC_N] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec, inv;
  logic        wr, rd;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #4 clk = ~clk;

  fuse_cmd_seq #(
    .NUM_WORDS (NW), .IDX_W (IW), .BUSY_LAT (BL), .PWR_LAT (PL),
    .INIT_IMG (IMG), .WEAK_MAP (WEAK)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .lc_secured_i (sec), .lc_invalid_i (inv),
    .bus_wr (wr), .bus_rd (rd), .bus_addr (addr), .bus_wdata (wdata),
    .bus_rdata (rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<50000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 100; k++) begin
      brd(12'h00C, s);
      if (!s[3]) break;
    end
  endtask

  task automatic wait_pwr(input bit lvl);
    logic [31:0] s;
    for (int k = 0; k < 100; k++) begin
      brd(12'h00C, s);
      if (s[5] == lvl) break;
    end
  endtask

  task automatic cmd(input logic [9:0] ctl, input logic [31:0] d);
    bwr(12'h008, d);
    bwr(12'h004, {22'd0, ctl});
    wait_idle();
  endtask

  function automatic logic [11:0] sh_a(input int i);
    return 12'(12'h200 + 4 * i);
  endfunction

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; sec = 1'b0; inv = 1'b0;
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    brd(12'h00C, v); check(v == 32'h0, "R1 status", v, 32'h0);
    brd(12'h000, v); check(v == 32'h0, "R1 cfg", v, 32'h0);
    brd(sh_a(0), v); check(v == 32'h0, "R1 shadow0", v, 32'h0);
    brd(12'h034, v); check(v == 32'h0, "R1 err bank0", v, 32'h0);
    brd(12'h01C, v); check(v == 32'h0, "R1 dist bank0", v, 32'h0);

    // R11 status mirrors security inputs
    sec = 1'b1; inv = 1'b1;
    brd(12'h00C, v); check(v[0] && v[2], "R11 sec/inv set", v, 32'h5);
    sec = 1'b0; inv = 1'b0;
    brd(12'h00C, v); check(!v[0] && !v[2], "R11 sec/inv clr", v, 32'h0);

    // R3 command ignored while powered down
    bwr(12'h004, 32'h0000_0007);
    brd(12'h00C, v); check(!v[3], "R3 no busy", v, 32'h0);
    repeat (BL + 2) @(negedge clk);
    brd(sh_a(7), v); check(v == 32'h0, "R3 shadow untouched", v, 32'h0);

    // R2 power up latency
    bwr(12'h000, 32'h1);
    brd(12'h00C, v); check(!v[5], "R2 not yet up", v, 32'h0);
    wait_pwr(1'b1);
    brd(12'h00C, v); check(v[5], "R2 power up", v, 32'h20);

    // R5 / R9 vector table of shadow reads
    for (int n = 0; n < VEC_N; n++) begin
      int ix;
      ix = int'(VEC_IDX[n]);
      cmd({3'b000, VEC_IDX[n]}, 32'h0);
      brd(sh_a(ix), v);
      check(v == img(ix), "R5 shadow read", v, img(ix));
      brd(12'(12'h01C + 4 * (ix >> 5)), v);
      check(v[ix % 32] == VEC_DIST[n], "R9 disturbed bit", {31'd0, v[ix % 32]}, {31'd0, VEC_DIST[n]});
    end

    // R4 busy timing and a second command while busy
    bwr(12'h008, 32'hFFFF_FFFF);
    bwr(12'h004, 32'h0000_0003);
    bwr(12'h004, 32'h0000_0103);
    brd(12'h00C, v); check(v[3], "R4 busy high", v, 32'h28);
    wait_idle();
    brd(12'h00C, v); check(!v[3], "R4 busy cleared", v, 32'h20);
    cmd(10'h003, 32'h0);
    brd(sh_a(3), v); check(v == img(3), "R4 ignored program", v, img(3));

    // R6 program ORs into fuse word
    cmd(10'h10A, 32'h0000_F00F);
    cmd(10'h00A, 32'h0);
    brd(sh_a(10), v); check(v == (img(10) | 32'h0000_F00F), "R6 program OR", v, img(10) | 32'h0000_F00F);

    // R7 lock then program fails
    cmd(10'h30C, 32'h0);
    cmd(10'h10C, 32'hFFFF_FFFF);
    brd(12'h00C, v); check(v[4], "R7 prog fail set", v, 32'h30);
    cmd(10'h00C, 32'h0);
    brd(sh_a(12), v); check(v == img(12), "R7 locked word unchanged", v, img(12));
    brd(12'h00C, v); check(!v[4], "R7 prog fail cleared", v, 32'h20);

    // R8 out-of-range index
    bwr(12'h004, 32'h0000_0064);
    brd(12'h00C, v); check(!v[3], "R8 no busy", v, 32'h20);
    brd(12'h040, v); check(v == 32'h0000_0010, "R8 err bit", v, 32'h10);

    // R10 shadow write stays in shadow
    bwr(sh_a(20), 32'hDEAD_BEEF);
    brd(sh_a(20), v); check(v == 32'hDEAD_BEEF, "R10 shadow write", v, 32'hDEAD_BEEF);
    cmd(10'h014, 32'h0);
    brd(sh_a(20), v); check(v == img(20), "R10 fuse untouched", v, img(20));

    // R2 power down
    bwr(12'h000, 32'h0);
    wait_pwr(1'b0);
    brd(12'h00C, v); check(!v[5], "R2 power down", v, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule